// File: doc/BRIEF.md
# Multichannel DAC Update Sequencer

This block sits on a byte-wide register bus with a 4-bit offset and separate write and read strobes. It loads 12-bit codes into twelve DAC channel latches. A code is assembled from two byte writes to one data port, low byte first. The code then goes to a channel in one of two ways. In direct I/O mode, software writes the channel number to the control register. In paced DMA mode, each pacing pulse raises a request. The host's acknowledge strobes then carry the two bytes of one sample, and the sample lands in the selected channel once the high byte arrives.

In DMA mode the block can step the selected channel after every sample. The pointer runs through sixteen slots: twelve real channels and four phantom slots that take a sample but drive nothing. Each channel has an active-low disable bit. A read of the control offset resets the sequencing state, restarts a DMA transfer when DMA mode is selected, and clears the end-of-transfer interrupt. That interrupt is raised by a terminal-count pulse when continuous cycling is off.

Top module: `dac_update_seq`

## Requirements
- R1: After reset all channel codes are 0, every channel is disabled (`ch_out_en` = 0), `dma_req`, `irq` and both timer enables are 0, and `cycle_mode_en` is 0.
- R2: Two writes to offset 3 form a code: the first byte gives bits 7:0 and bits 3:0 of the second byte give bits 11:8; the upper nibble of the second byte is ignored. In I/O mode (control bit 5 = 0), a control write (offset 0) with bits 3:0 = n in 1..12 loads that code into channel n one cycle later. No other channel changes.
- R3: In I/O mode, a control write with bits 3:0 = 0 loads the held code into the channel selected last. Selections 13 to 15 load nothing.
- R4: A read of offset 0 resets the byte pointer, so the next data byte is taken as a low byte.
- R5: Offset 1 bit k disables channel k+1, and offset 2 bits 3:0 disable channels 9 to 12. A value of 1 disables and 0 enables. `ch_out_en` shows the inverse of these bits, and a load aimed at a disabled channel leaves its code unchanged.
- R6: In DMA mode (control bit 5 = 1, bit 4 = 1), a read of offset 0 starts a transfer. Each later `pace_tick` raises `dma_req` one cycle later. Each `dma_ack` delivers `bus_wdata` as one byte. `dma_req` falls after the second acknowledge, and that acknowledge loads the sample into the selected channel.
- R7: With offset 2 bit 4 = 1 in DMA mode, the selected slot steps after every sample, from 12 through the phantom slots 13 to 16 and then back to 1. Phantom slots and disabled channels change no output but still step.
- R8: The scan bit has no effect in I/O mode: the selection does not move after a load.
- R9: With offset 2 bit 5 = 1, a `dma_tc` pulse during a transfer sets `irq` and ends the transfer. `irq` holds until a read of offset 0 clears it. With bit 5 = 0, `dma_tc` leaves `irq` at 0, and `cycle_mode_en` is then 1.
- R10: `pace_timer_en` and `spare_timer_en` follow control bits 6 and 7.
- R11: A `pace_tick` in the same cycle as a high-byte acknowledge leaves `dma_req` asserted for the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data, also the DMA byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| pace_tick | input | 1 | Pacing pulse |
| dma_ack | input | 1 | DMA acknowledge, one byte each |
| dma_tc | input | 1 | Terminal-count pulse |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | End-of-transfer interrupt level |
| pace_timer_en | output | 1 | Pacing timer enable |
| spare_timer_en | output | 1 | Spare timer enable |
| cycle_mode_en | output | 1 | Continuous cycle mode enabled |
| ch_out_en | output | 12 | Per-channel output enable |
| ch_code | output | 144 | Channel codes, channel n at bits 12n-1:12n-12 |

## Verification
Two functions can fall in the same cycle: the pacing pulse that asks for the next sample, and the high-byte acknowledge that retires the current one. The bench runs a scan of more than two full sixteen-slot rounds. In one of those samples it drives the tick and the final acknowledge together. It then expects `dma_req` to stay high with no further tick, and it expects the next sample to land in the next slot. Every sample is compared against a slot model kept in the bench.

// File: rtl/dac_update_seq.sv
module dac_update_seq #(
  parameter int NCH   = 12,
  parameter int CW    = 12,
  parameter int SLOTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              pace_tick,
  input  logic              dma_ack,
  input  logic              dma_tc,
  output logic              dma_req,
  output logic              irq,
  output logic              pace_timer_en,
  output logic              spare_timer_en,
  output logic              cycle_mode_en,
  output logic [NCH-1:0]    ch_out_en,
  output logic [NCH*CW-1:0] ch_code
);

  localparam int SW = $clog2(SLOTS + 1);
  localparam int HW = CW - 8;

  logic          req_en_q, dma_mode_q, ptimer_q, stimer_q;
  logic [SW-1:0] sel_q;
  logic [NCH-1:0] dis_q;
  logic          scan_q, cyc_dis_q;
  logic [7:0]    lo_q;
  logic          hi_ptr_q, running_q;
  logic [CW-1:0] hold_q;

  wire wr_ctrl = bus_wr && bus_addr == 4'd0;
  wire wr_en1  = bus_wr && bus_addr == 4'd1;
  wire wr_en2  = bus_wr && bus_addr == 4'd2;
  wire wr_data = bus_wr && bus_addr == 4'd3;
  wire rd_ctrl = bus_rd && bus_addr == 4'd0;

  wire           byte_stb  = wr_data || (dma_ack && dma_mode_q);
  wire [CW-1:0]  assembled = {bus_wdata[HW-1:0], lo_q};
  wire           dma_upd   = dma_ack && dma_mode_q && running_q && hi_ptr_q;
  wire           io_upd    = wr_ctrl && !bus_wdata[5];
  wire [SW-1:0]  io_tgt    = (bus_wdata[3:0] != 4'd0) ? SW'(bus_wdata[3:0]) : sel_q;
  wire [SW-1:0]  upd_slot  = io_upd ? io_tgt : sel_q;
  wire [CW-1:0]  upd_val   = io_upd ? hold_q : assembled;
  wire           upd_any   = io_upd || dma_upd;
  wire           tc_end    = dma_tc && running_q && cyc_dis_q;

  logic [NCH-1:0] upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {stimer_q, ptimer_q, dma_mode_q, req_en_q} <= '0;
      sel_q <= SW'(1);
    end else begin
      if (wr_ctrl) {stimer_q, ptimer_q, dma_mode_q, req_en_q} <= bus_wdata[7:4];
      if (wr_ctrl && bus_wdata[3:0] != 4'd0)
        sel_q <= SW'(bus_wdata[3:0]);
      else if (dma_upd && scan_q)
        sel_q <= (sel_q == SW'(SLOTS)) ? SW'(1) : sel_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q     <= '1;
      scan_q    <= 1'b0;
      cyc_dis_q <= 1'b1;
    end else begin
      if (wr_en1) dis_q[7:0] <= bus_wdata;
      if (wr_en2) begin
        dis_q[NCH-1:8] <= bus_wdata[NCH-9:0];
        scan_q         <= bus_wdata[4];
        cyc_dis_q      <= bus_wdata[5];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_ptr_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      if (rd_ctrl)       hi_ptr_q <= 1'b0;
      else if (byte_stb) hi_ptr_q <= !hi_ptr_q;
      if (byte_stb && !hi_ptr_q) lo_q <= bus_wdata;
      if (byte_stb && hi_ptr_q)  hold_q <= assembled;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      dma_req   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_ctrl && !bus_wdata[5]) running_q <= 1'b0;
      else if (rd_ctrl)             running_q <= dma_mode_q;
      else if (tc_end)              running_q <= 1'b0;

      if ((wr_ctrl && !(bus_wdata[4] && bus_wdata[5])) || rd_ctrl || tc_end)
        dma_req <= 1'b0;
      else if (pace_tick && running_q && req_en_q)
        dma_req <= 1'b1;
      else if (dma_ack && hi_ptr_q)
        dma_req <= 1'b0;

      if (tc_end)       irq <= 1'b1;
      else if (rd_ctrl) irq <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign upd[i]       = upd_any && upd_slot == SW'(i + 1) && !dis_q[i];
    assign ch_out_en[i] = !dis_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ch_code[i*CW +: CW] <= '0;
      else if (upd[i]) ch_code[i*CW +: CW] <= upd_val;
    end
    assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_out_en[i] |=> $stable(ch_code[i*CW +: CW]));
  end

  assign pace_timer_en  = ptimer_q;
  assign spare_timer_en = stimer_q;
  assign cycle_mode_en  = !cyc_dis_q;

  assert_single_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd));
  assert_req_from_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(pace_tick));
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(dma_tc));
  assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !rd_ctrl |=> irq);
  assert_irq_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl && !dma_tc |=> !irq);

endmodule

// File: tb/test_dac_update_seq.sv
`timescale 1ns/1ps
module test_dac_update_seq;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0, pace_tick = 0, dma_ack = 0, dma_tc = 0;
  logic dma_req, irq, pace_timer_en, spare_timer_en, cycle_mode_en;
  logic [11:0] ch_out_en;
  logic [143:0] ch_code;

  dac_update_seq i_dac_update_seq (.*);

  always #2.5 clk = !clk;

  int nchk = 0, nerr = 0;
  int exp_code [1:12];
  bit exp_dis [1:12];

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int c = 1; c <= 12; c++) check(tag, int'(ch_code[(c-1)*12 +: 12]), exp_code[c]);
  endtask

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic brd0();
    bus_addr = 0; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic ack(input logic [7:0] d, input bit with_tick);
    bus_wdata = d; dma_ack = 1; pace_tick = with_tick;
    @(negedge clk); dma_ack = 0; pace_tick = 0;
  endtask

  task automatic pulse_tick();
    pace_tick = 1; @(negedge clk); pace_tick = 0;
  endtask

  task automatic pulse_tc();
    dma_tc = 1; @(negedge clk); dma_tc = 0;
  endtask

  task automatic load_io(input int v);
    bwr(4'd3, 8'(v & 'hFF));
    bwr(4'd3, 8'(8'hA0 | ((v >> 8) & 'hF)));
  endtask

  initial begin
    #500000;
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int v, slot;
    for (int c = 1; c <= 12; c++) begin exp_code[c] = 0; exp_dis[c] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 req", dma_req, 0);
    check("R1 irq", irq, 0);
    check("R1 en", int'(ch_out_en), 0);
    check("R1 timers", {pace_timer_en, spare_timer_en, cycle_mode_en}, 0);
    check_all("R1 codes");

    // R5 enable all
    bwr(4'd1, 8'h00); bwr(4'd2, 8'h00);
    for (int c = 1; c <= 12; c++) exp_dis[c] = 0;
    check("R5 en", int'(ch_out_en), 'hFFF);
    check("R9 cycle_mode_en", cycle_mode_en, 1);

    // R2 I/O sweep
    for (int c = 1; c <= 12; c++) begin
      v = (c * 293 + 17) & 'hFFF;
      load_io(v);
      bwr(4'd0, 8'(8'hC0 | c));
      exp_code[c] = v;
      check_all("R2 io load");
    end
    check("R10 both timers", {pace_timer_en, spare_timer_en}, 3);

    // R3 write 0 reloads last (12); 13 loads nothing
    load_io('h5A5); bwr(4'd0, 8'h00); exp_code[12] = 'h5A5;
    check_all("R3 reload");
    load_io('h777); bwr(4'd0, 8'h0D); bwr(4'd0, 8'h00);
    check_all("R3 phantom io");

    // R10
    bwr(4'd0, 8'h40);
    check("R10 pace only", {pace_timer_en, spare_timer_en}, 2);
    bwr(4'd0, 8'h80);
    check("R10 spare only", {pace_timer_en, spare_timer_en}, 1);

    // R4 read resets byte pointer
    bwr(4'd3, 8'h55); brd0();
    bwr(4'd3, 8'h34); bwr(4'd3, 8'h02); bwr(4'd0, 8'h05);
    exp_code[5] = 'h234;
    check_all("R4 pointer reset");

    // R5 disable 3 and 10
    bwr(4'd1, 8'h04); bwr(4'd2, 8'h02);
    exp_dis[3] = 1; exp_dis[10] = 1;
    check("R5 en mask", int'(ch_out_en), 'hFFF & ~('h004 | 'h200));
    load_io('h9C3); bwr(4'd0, 8'h03); bwr(4'd0, 8'h0A);
    check_all("R5 suppressed");
    bwr(4'd0, 8'h04); exp_code[4] = 'h9C3;
    check_all("R5 enabled load");

    // R8 scan ignored in I/O mode
    bwr(4'd2, 8'h12);
    load_io('h111); bwr(4'd0, 8'h06); exp_code[6] = 'h111;
    load_io('h222); bwr(4'd0, 8'h00); exp_code[6] = 'h222;
    check_all("R8 no step in io");

    // R6/R7/R11 DMA scan
    bwr(4'd2, 8'h30); exp_dis[10] = 0;
    bwr(4'd0, 8'h71);
    brd0();
    slot = 1;
    for (int s = 0; s < 36; s++) begin
      v = (s * 611 + 3) & 'hFFF;
      if (s != 6) pulse_tick();
      check("R6 req up", dma_req, 1);
      ack(8'(v & 'hFF), 0);
      check("R6 req mid", dma_req, 1);
      ack(8'(v >> 8), s == 5);
      if (slot <= 12 && !exp_dis[slot]) exp_code[slot] = v;
      slot = (slot == 16) ? 1 : slot + 1;
      check("R11/R6 req after sample", dma_req, s == 5 ? 1 : 0);
      check_all("R7 scan");
    end

    // R9 interrupt
    pulse_tc();
    check("R9 irq set", irq, 1);
    repeat (3) @(negedge clk);
    check("R9 irq held", irq, 1);
    pulse_tick();
    check("R9 no req after end", dma_req, 0);
    brd0();
    check("R9 irq cleared", irq, 0);
    bwr(4'd2, 8'h10);
    check("R9 cycle_mode_en", cycle_mode_en, 1);
    pulse_tc();
    check("R9 no irq in cycle mode", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule